// File: doc/BRIEF.md
# Weighted Scan Transition Power Meter

This block estimates the power of shifting scan test vectors. Each vector arrives one bit per cycle, already fully filled with zeros and ones. The block counts the transitions between neighbouring bits, and each transition is weighted by how far it sits from the end of the vector. A transition near the scan input is shifted through more flops, so it costs more.

For every vector the block reports its metric one cycle after the last bit. It also keeps a running total and a count of the vectors seen since reset. When the user asks for it, a sequential divider returns the average metric per vector. The vector length is given with the first bit of each vector. It may differ between vectors, up to a parameter maximum.

Top module: `wtmPowerMeter`

## Requirements
- R1: For a vector of length l with bits b1..bl, where b1 is the first bit shifted in, the metric is the sum over j = 1..l-1 of (bj XOR bj+1) * (l - j). The vector 10001110 gives 12 and the vector 11010001 gives 16 (l = 8, written b1 first).
- R2: `vecDone` is high for exactly one cycle, the cycle after the one in which the last bit is accepted. `vecMetric` then holds that vector's metric until the next vector completes.
- R3: `vecLen` is sampled with the first bit. A vector of length 1 yields metric 0, and no transition is counted between the last bit of one vector and the first bit of the next.
- R4: `totalMetric` is the sum of the metrics of all vectors completed since reset, and `vecCount` is their number. Both update in the same cycle that `vecDone` rises.
- R5: A pulse on `avgReq` while `avgBusy` is low starts a division. It later raises `avgDone` for one cycle with `avgValue` = floor(total / count), both taken at the request. If the count is 0, the average is 0.
- R6: A bit with `shiftValid` high is ignored when it does not carry `vecFirst` and no vector is open. This holds even when it carries `vecLast`. Inputs with `shiftValid` low are also ignored.
- R7: `vecFirst` during an open vector drops the partial vector without reporting it and starts a new one.
- R8: After reset, `vecDone`, `avgDone` and `avgBusy` are low, and `vecMetric`, `totalMetric`, `vecCount` and `avgValue` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| shiftValid | input | 1 | A scan bit is present this cycle |
| shiftBit | input | 1 | Scan bit value |
| vecFirst | input | 1 | This bit is the first of a vector |
| vecLast | input | 1 | This bit is the last of a vector |
| vecLen | input | LEN_W | Vector length, sampled with the first bit |
| avgReq | input | 1 | Request an average computation |
| vecMetric | output | MET_W | Metric of the last completed vector |
| vecDone | output | 1 | One-cycle pulse: `vecMetric` is new |
| totalMetric | output | TOT_W | Sum of metrics since reset |
| vecCount | output | CNT_W | Vectors completed since reset |
| avgBusy | output | 1 | Division in progress |
| avgDone | output | 1 | One-cycle pulse: `avgValue` is new |
| avgValue | output | TOT_W | Average metric per vector |

## Verification
The bench builds the block with MAX_LEN = 16 and MAX_VECS = 8. With these values the maximum-length vector of alternating bits (metric 120) and a full run of eight vectors are cheap to exercise. The total stays at or below its sized bound, and the 11-bit divider finishes within a few cycles. These values also make the exact floor of a non-integer average easy to check against a reference model run on random vectors of random length.

// File: rtl/wtm_pkg.sv
package wtm_pkg;
  typedef struct packed {
    logic loadFirst;
    logic stepPair;
    logic finish;
    logic startDiv;
  } wtmStrobe_t;
endpackage

// File: rtl/wtmCtrl.sv
module wtmCtrl
  import wtm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       shiftValid,
  input  logic       vecFirst,
  input  logic       vecLast,
  input  logic       avgReq,
  input  logic       divBusy,
  output wtmStrobe_t stb
);
  logic vecOpen;

  always_comb begin
    stb.loadFirst = shiftValid && vecFirst;
    stb.stepPair  = shiftValid && !vecFirst && vecOpen;
    stb.finish    = shiftValid && vecLast && (vecFirst || vecOpen);
    stb.startDiv  = avgReq && !divBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecOpen <= 1'b0;
    end else if (stb.finish) begin
      vecOpen <= 1'b0;
    end else if (stb.loadFirst) begin
      vecOpen <= 1'b1;
    end
  end
endmodule

// File: rtl/wtmDatapath.sv
module wtmDatapath
  import wtm_pkg::*;
#(
  parameter int LEN_W = 7,
  parameter int MET_W = 12,
  parameter int TOT_W = 22,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  wtmStrobe_t       stb,
  input  logic             shiftBit,
  input  logic [LEN_W-1:0] vecLen,
  output logic [MET_W-1:0] vecMetric,
  output logic             vecDone,
  output logic [TOT_W-1:0] totalMetric,
  output logic [CNT_W-1:0] vecCount
);
  logic             prevBit;
  logic [LEN_W-1:0] weight;
  logic [MET_W-1:0] acc;
  logic [MET_W-1:0] term;
  logic [MET_W-1:0] accNext;
  logic [MET_W-1:0] finalMetric;

  always_comb begin
    term        = (prevBit ^ shiftBit) ? MET_W'(weight) : '0;
    accNext     = acc + term;
    finalMetric = stb.loadFirst ? '0 : accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBit <= 1'b0;
      weight  <= '0;
      acc     <= '0;
    end else if (stb.loadFirst) begin
      prevBit <= shiftBit;
      weight  <= vecLen - LEN_W'(1);
      acc     <= '0;
    end else if (stb.stepPair) begin
      prevBit <= shiftBit;
      weight  <= weight - LEN_W'(1);
      acc     <= accNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecMetric   <= '0;
      vecDone     <= 1'b0;
      totalMetric <= '0;
      vecCount    <= '0;
    end else begin
      vecDone <= stb.finish;
      if (stb.finish) begin
        vecMetric   <= finalMetric;
        totalMetric <= totalMetric + TOT_W'(finalMetric);
        vecCount    <= vecCount + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/wtmDivider.sv
module wtmDivider #(
  parameter int NUM_W = 22,
  parameter int DEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quotient
);
  localparam int ITER_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]    rem;
  logic [NUM_W-1:0]  work;
  logic [DEN_W-1:0]  den;
  logic [ITER_W-1:0] left;
  logic [DEN_W:0]    trial;
  logic              fits;

  always_comb begin
    trial = {rem[DEN_W-1:0], work[NUM_W-1]};
    fits  = trial >= {1'b0, den};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rem      <= '0;
      work     <= '0;
      den      <= '0;
      left     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        rem  <= '0;
        work <= dividend;
        den  <= divisor;
        left <= ITER_W'(NUM_W);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? trial - {1'b0, den} : trial;
        work <= {work[NUM_W-2:0], fits};
        left <= left - ITER_W'(1);
        if (left == ITER_W'(1)) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          quotient <= (den == '0) ? '0 : {work[NUM_W-2:0], fits};
        end
      end
    end
  end
endmodule

// File: rtl/wtmPowerMeter.sv
module wtmPowerMeter
  import wtm_pkg::*;
#(
  parameter int MAX_LEN  = 64,
  parameter int MAX_VECS = 1024,
  localparam int LEN_W = $clog2(MAX_LEN + 1),
  localparam int MET_W = $clog2(MAX_LEN * MAX_LEN / 2 + 1),
  localparam int TOT_W = $clog2(MAX_VECS * MAX_LEN * MAX_LEN / 2 + 1),
  localparam int CNT_W = $clog2(MAX_VECS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftValid,
  input  logic             shiftBit,
  input  logic             vecFirst,
  input  logic             vecLast,
  input  logic [LEN_W-1:0] vecLen,
  input  logic             avgReq,
  output logic [MET_W-1:0] vecMetric,
  output logic             vecDone,
  output logic [TOT_W-1:0] totalMetric,
  output logic [CNT_W-1:0] vecCount,
  output logic             avgBusy,
  output logic             avgDone,
  output logic [TOT_W-1:0] avgValue
);
  wtmStrobe_t stb;

  wtmCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .shiftValid(shiftValid), .vecFirst(vecFirst),
    .vecLast(vecLast), .avgReq(avgReq), .divBusy(avgBusy), .stb(stb)
  );

  wtmDatapath #(.LEN_W(LEN_W), .MET_W(MET_W), .TOT_W(TOT_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .shiftBit(shiftBit), .vecLen(vecLen),
    .vecMetric(vecMetric), .vecDone(vecDone), .totalMetric(totalMetric),
    .vecCount(vecCount)
  );

  wtmDivider #(.NUM_W(TOT_W), .DEN_W(CNT_W)) i_div (
    .clk(clk), .rstN(rstN), .start(stb.startDiv), .dividend(totalMetric),
    .divisor(vecCount), .busy(avgBusy), .done(avgDone), .quotient(avgValue)
  );
endmodule

// File: rtl/wtmPowerMeter_chk.sv
module wtmPowerMeter_chk #(
  parameter int MAX_LEN = 64,
  parameter int MET_W   = 12,
  parameter int TOT_W   = 22,
  parameter int CNT_W   = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             shiftValid,
  input logic             vecLast,
  input logic [MET_W-1:0] vecMetric,
  input logic             vecDone,
  input logic [TOT_W-1:0] totalMetric,
  input logic [CNT_W-1:0] vecCount,
  input logic             avgBusy,
  input logic             avgDone
);
  p_done_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    vecDone |-> $past(shiftValid && vecLast));

  p_metric_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    vecDone |-> (vecMetric <= MET_W'(MAX_LEN * (MAX_LEN - 1) / 2)));

  p_total_adds_r4: assert property (@(posedge clk) disable iff (!rstN)
    vecDone |-> (totalMetric == $past(totalMetric) + TOT_W'(vecMetric))
                && (vecCount == $past(vecCount) + CNT_W'(1)));

  p_total_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    !vecDone |-> ($stable(totalMetric) && $stable(vecCount)));

  p_stray_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    !shiftValid |=> !vecDone);

  p_avg_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    avgDone |-> ($past(avgBusy) && !avgBusy));
endmodule

bind wtmPowerMeter wtmPowerMeter_chk #(
  .MAX_LEN(MAX_LEN), .MET_W(MET_W), .TOT_W(TOT_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rstN(rstN), .shiftValid(shiftValid), .vecLast(vecLast),
  .vecMetric(vecMetric), .vecDone(vecDone), .totalMetric(totalMetric),
  .vecCount(vecCount), .avgBusy(avgBusy), .avgDone(avgDone)
);

// File: tb/test_wtmPowerMeter.sv
module test_wtmPowerMeter;
  localparam int MAX_LEN  = 16;
  localparam int MAX_VECS = 8;
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int MET_W = $clog2(MAX_LEN * MAX_LEN / 2 + 1);
  localparam int TOT_W = $clog2(MAX_VECS * MAX_LEN * MAX_LEN / 2 + 1);
  localparam int CNT_W = $clog2(MAX_VECS + 1);
  localparam int NTAB  = 8;

  // bits right-aligned, b1 is the most significant of the len bits
  localparam logic [15:0] T_BITS [NTAB] = '{16'b10001110, 16'b11010001, 16'hAAAA,
    16'h0000, 16'b1, 16'b10, 16'b011, 16'h8000};
  localparam int T_LEN [NTAB] = '{8, 8, 16, 16, 1, 2, 3, 16};
  localparam int T_EXP [NTAB] = '{12, 16, 120, 0, 0, 1, 2, 15};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftValid = 1'b0, shiftBit = 1'b0, vecFirst = 1'b0, vecLast = 1'b0;
  logic [LEN_W-1:0] vecLen = '0;
  logic avgReq = 1'b0;
  logic [MET_W-1:0] vecMetric;
  logic vecDone;
  logic [TOT_W-1:0] totalMetric;
  logic [CNT_W-1:0] vecCount;
  logic avgBusy, avgDone;
  logic [TOT_W-1:0] avgValue;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  wtmPowerMeter #(.MAX_LEN(MAX_LEN), .MAX_VECS(MAX_VECS)) i_wtmPowerMeter (
    .clk(clk), .rstN(rstN), .shiftValid(shiftValid), .shiftBit(shiftBit),
    .vecFirst(vecFirst), .vecLast(vecLast), .vecLen(vecLen), .avgReq(avgReq),
    .vecMetric(vecMetric), .vecDone(vecDone), .totalMetric(totalMetric),
    .vecCount(vecCount), .avgBusy(avgBusy), .avgDone(avgDone), .avgValue(avgValue)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int refMetric(input logic [15:0] bits, input int len);
    int sum = 0;
    for (int j = 1; j < len; j++)
      if (bits[len - j] != bits[len - j - 1]) sum += len - j;
    return sum;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // drives len bits from the given b1 position; done is checked at the next negedge
  task automatic sendBits(input logic [15:0] bits, input int len, input int nSend,
                          input bit markLast);
    for (int k = 0; k < nSend; k++) begin
      @(negedge clk);
      shiftValid = 1'b1;
      shiftBit   = bits[len - 1 - k];
      vecFirst   = (k == 0);
      vecLast    = markLast && (k == nSend - 1);
      vecLen     = LEN_W'(len);
    end
    @(negedge clk);
    shiftValid = 1'b0; vecFirst = 1'b0; vecLast = 1'b0;
  endtask

  task automatic getAvg(output longint val);
    int n = 0;
    @(negedge clk);
    avgReq = 1'b1;
    @(negedge clk);
    avgReq = 1'b0;
    while (!avgDone && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(avgDone, "R5 avgDone seen", avgDone, 1);
    val = avgValue;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint runTotal;
    longint avgGot;
    doReset();
    @(negedge clk);
    // R8 reset state
    chk(vecDone == 0 && avgDone == 0 && avgBusy == 0, "R8 flags", {vecDone, avgDone, avgBusy}, 0);
    chk(vecMetric == 0 && totalMetric == 0 && vecCount == 0 && avgValue == 0,
        "R8 values", totalMetric + vecMetric + vecCount + avgValue, 0);

    // table walk: R1, R2, R3
    runTotal = 0;
    for (int t = 0; t < NTAB; t++) begin
      sendBits(T_BITS[t], T_LEN[t], T_LEN[t], 1'b1);
      chk(vecDone == 1, "R2 done pulse", vecDone, 1);
      chk(vecMetric == MET_W'(T_EXP[t]), "R1/R3 metric", vecMetric, T_EXP[t]);
      runTotal += T_EXP[t];
      @(negedge clk);
      chk(vecDone == 0, "R2 single cycle", vecDone, 0);
      chk(vecMetric == MET_W'(T_EXP[t]), "R2 metric held", vecMetric, T_EXP[t]);
    end
    chk(totalMetric == TOT_W'(runTotal), "R4 total", totalMetric, runTotal);
    chk(vecCount == CNT_W'(NTAB), "R4 count", vecCount, NTAB);
    getAvg(avgGot);
    chk(avgGot == runTotal / NTAB, "R5 average floor", avgGot, runTotal / NTAB);

    // R5 zero count
    doReset();
    getAvg(avgGot);
    chk(avgGot == 0, "R5 zero count", avgGot, 0);

    // R6 stray bits outside a vector, one marked last
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      shiftValid = 1'b1; shiftBit = k[0]; vecFirst = 1'b0; vecLast = (k == 2);
      vecLen = LEN_W'(8);
      @(negedge clk);
      shiftValid = 1'b0; vecLast = 1'b0;
      chk(vecDone == 0, "R6 stray no done", vecDone, 0);
    end
    @(negedge clk);
    chk(totalMetric == 0 && vecCount == 0, "R6 stray no total", totalMetric, 0);

    // R7 restart mid-vector
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      shiftValid = 1'b1; shiftBit = ~k[0]; vecFirst = (k == 0); vecLast = 1'b0;
      vecLen = LEN_W'(8);
    end
    sendBits(16'b11010001, 8, 8, 1'b1);
    chk(vecDone == 1 && vecMetric == 16, "R7 restart metric", vecMetric, 16);
    @(negedge clk);
    chk(vecCount == 1 && totalMetric == 16, "R7 partial dropped", totalMetric, 16);

    // random vectors against reference model: R1, R4, R5
    runTotal = 16;
    for (int r = 0; r < 6; r++) begin
      logic [15:0] bits;
      int len;
      int expv;
      bits = 16'($urandom);
      len  = 2 + int'($urandom % 15);
      bits = bits & 16'((32'h1 << len) - 1);
      expv = refMetric(bits, len);
      sendBits(bits, len, len, 1'b1);
      chk(vecDone == 1 && vecMetric == MET_W'(expv), "R1 random metric", vecMetric, expv);
      runTotal += expv;
    end
    @(negedge clk);
    chk(totalMetric == TOT_W'(runTotal), "R4 random total", totalMetric, runTotal);
    chk(vecCount == 7, "R4 random count", vecCount, 7);
    getAvg(avgGot);
    chk(avgGot == runTotal / 7, "R5 random average", avgGot, runTotal / 7);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule